// File: doc/BRIEF.md
# Disk Controller Soft-Switch Decoder

This block sits behind the sixteen I/O addresses that a disk-controller slot owns. The host gives it a select strobe, a direction bit and the low four address bits, called the offset. Every offset is an action, and the block takes it whether the access is a read or a write. Offsets 0 to 7 move single stepper phase lines. Offsets 8 to B switch the spindle motor and choose between two drives. Offsets E and F choose between read and write mode for the external shifter. Offset C fires the shifter strobe. Offset D gives access to an 8-bit data latch.

The control outputs come from registers and change on the clock edge that takes the access. Read data and the shift strobe are combinational from the current access, so the host gets its byte in the same cycle. The asynchronous active-low reset is released through a two-stage synchronizer. After reset, all phases are low, the motor is off, drive 1 is selected, read mode is active and the data latch holds 0x00.

Top module: `disk_switch_ctrl`

## Requirements
- R1: After reset, `phase` is 4'b0000, `motor_on` is 0, `drive_sel` is 0 (drive 1), `write_mode` is 0 (read mode), and reading offset D returns 0x00.
- R2: An access to offset 0..7, read or write, sets `phase[offset[2:1]]` to `offset[0]` at the next clock edge. The other three phases keep their values.
- R3: An access to offset 8 clears `motor_on` and an access to offset 9 sets it, at the next clock edge, for either direction.
- R4: An access to offset A sets `drive_sel` to 0 (drive 1) and an access to offset B sets it to 1 (drive 2), at the next clock edge, for either direction.
- R5: `shift_strobe` is high in exactly those cycles that carry an access to offset C, read or write.
- R6: A read of offset C returns `shift_data` on `rdata` in the same cycle.
- R7: A write to offset D loads `wdata` into the data latch at the clock edge. A read of offset D returns the latch contents in the same cycle. Reads of D and writes to other offsets leave the latch unchanged.
- R8: An access to offset E clears `write_mode` and an access to offset F sets it, at the next clock edge, for either direction.
- R9: `rdata` is 0x00 in any cycle that is not a read of offset C or D.
- R10: In a cycle with `sel` low, no control output and no latch bit changes at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Access to one of the slot's sixteen I/O addresses in this cycle |
| wr | input | 1 | Access direction: 1 write, 0 read |
| offset | input | 4 | Address bits 3:0 of the access |
| wdata | input | 8 | Write data bus |
| shift_data | input | 8 | Byte presented by the external read/write shifter |
| rdata | output | 8 | Read data, valid in the access cycle |
| shift_strobe | output | 1 | Strobe to the shifter, high for one access to offset C |
| phase | output | 4 | Stepper phase lines, bit n is phase n |
| motor_on | output | 1 | Spindle motor enable |
| drive_sel | output | 1 | 0 selects drive 1, 1 selects drive 2 |
| write_mode | output | 1 | 1 write mode, 0 read mode |

## Verification
The two results of an access arrive at different times. `rdata` and `shift_strobe` belong to the access cycle itself, so the bench checks them one time unit after it drives the inputs, before the edge. The phase, motor, drive and mode registers, and the data latch, take the access at the rising edge. The bench checks them at the falling edge that follows, against a behavioural model that it steps at that same edge. The latch is visible only through a later read of offset D, which the bench makes in the next access cycle.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int DSK_DW     = 8;
  localparam int DSK_NPH    = 4;
  localparam int DSK_PIDX_W = $clog2(DSK_NPH);
  localparam int DSK_OFS_W  = DSK_PIDX_W + 2;

  // offset[3:1] groups above the stepper range
  localparam logic [2:0] GRP_MOTOR = 3'b100;
  localparam logic [2:0] GRP_DRIVE = 3'b101;
  localparam logic [2:0] GRP_DATA  = 3'b110;
  localparam logic [2:0] GRP_MODE  = 3'b111;

  typedef struct packed {
    logic                  phase_we;
    logic [DSK_PIDX_W-1:0] phase_idx;
    logic                  motor_we;
    logic                  drive_we;
    logic                  mode_we;
    logic                  level;
    logic                  strobe;
    logic                  latch_ld;
    logic                  rd_shift;
    logic                  rd_latch;
  } dsk_act_t;
endpackage

// File: rtl/dsk_decode.sv
module dsk_decode
  import dsk_pkg::*;
(
  input  logic                 sel,
  input  logic                 wr,
  input  logic [DSK_OFS_W-1:0] offset,
  output dsk_act_t             act
);
  logic [2:0] grp;

  always_comb begin
    grp          = offset[3:1];
    act          = '0;
    act.level    = offset[0];
    act.phase_idx = offset[2:1];
    if (sel) begin
      if (!offset[3]) begin
        act.phase_we = 1'b1;
      end else begin
        unique case (grp)
          GRP_MOTOR: act.motor_we = 1'b1;
          GRP_DRIVE: act.drive_we = 1'b1;
          GRP_MODE:  act.mode_we  = 1'b1;
          GRP_DATA: begin
            if (!offset[0]) begin
              act.strobe   = 1'b1;
              act.rd_shift = !wr;
            end else begin
              act.latch_ld = wr;
              act.rd_latch = !wr;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsk_ctrl_regs.sv
module dsk_ctrl_regs
  import dsk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  dsk_act_t           act,
  output logic [DSK_NPH-1:0] phase,
  output logic               motor_on,
  output logic               drive_sel,
  output logic               write_mode
);
  logic [DSK_NPH-1:0] phase_d;
  logic               motor_d, drive_d, mode_d;

  generate
    for (genvar i = 0; i < DSK_NPH; i++) begin : g_phase
      logic hit;
      always_comb begin
        hit        = act.phase_we && (act.phase_idx == DSK_PIDX_W'(i));
        phase_d[i] = hit ? act.level : phase[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase[i] <= 1'b0;
        else if (hit) phase[i] <= phase_d[i];
      end
    end
  endgenerate

  always_comb begin
    motor_d = act.motor_we ? act.level : motor_on;
    drive_d = act.drive_we ? act.level : drive_sel;
    mode_d  = act.mode_we  ? act.level : write_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      motor_on   <= 1'b0;
      drive_sel  <= 1'b0;
      write_mode <= 1'b0;
    end else begin
      if (act.motor_we) motor_on   <= motor_d;
      if (act.drive_we) drive_sel  <= drive_d;
      if (act.mode_we)  write_mode <= mode_d;
    end
  end
endmodule

// File: rtl/dsk_data_latch.sv
module dsk_data_latch
  import dsk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dsk_act_t          act,
  input  logic [DSK_DW-1:0] wdata,
  input  logic [DSK_DW-1:0] shift_data,
  output logic [DSK_DW-1:0] rdata
);
  logic [DSK_DW-1:0] latch_q, latch_d;

  always_comb begin
    latch_d = act.latch_ld ? wdata : latch_q;
    if (act.rd_shift)      rdata = shift_data;
    else if (act.rd_latch) rdata = latch_q;
    else                   rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            latch_q <= '0;
    else if (act.latch_ld) latch_q <= latch_d;
  end
endmodule

// File: rtl/disk_switch_ctrl.sv
module disk_switch_ctrl
  import dsk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [DSK_OFS_W-1:0] offset,
  input  logic [DSK_DW-1:0]    wdata,
  input  logic [DSK_DW-1:0]    shift_data,
  output logic [DSK_DW-1:0]    rdata,
  output logic                 shift_strobe,
  output logic [DSK_NPH-1:0]   phase,
  output logic                 motor_on,
  output logic                 drive_sel,
  output logic                 write_mode
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  dsk_act_t   act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dsk_decode u_dec (.sel(sel), .wr(wr), .offset(offset), .act(act));

  dsk_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .act(act),
    .phase(phase), .motor_on(motor_on), .drive_sel(drive_sel),
    .write_mode(write_mode)
  );

  dsk_data_latch u_lat (
    .clk(clk), .rst_n(rst_sync_n), .act(act), .wdata(wdata),
    .shift_data(shift_data), .rdata(rdata)
  );

  assign shift_strobe = act.strobe;
endmodule

// File: rtl/dsk_switch_chk.sv
module dsk_switch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr,
  input logic [3:0] offset,
  input logic [7:0] rdata,
  input logic       shift_strobe,
  input logic [3:0] phase,
  input logic       motor_on,
  input logic       drive_sel,
  input logic       write_mode
);
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !offset[3]) |=> phase[$past(offset[2:1])] == $past(offset[0]));
  // R3
  motor_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && offset == 4'h8) |=> !motor_on);
  // R4
  drive_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && offset == 4'hB) |=> drive_sel);
  // R5
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_strobe |-> (sel && offset == 4'hC));
  // R8
  write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && offset == 4'hF) |=> write_mode);
  // R9
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr && offset[3:1] == 3'b110) |-> rdata == 8'h00);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable({phase, motor_on, drive_sel, write_mode}));
endmodule

bind disk_switch_ctrl dsk_switch_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sel(sel), .wr(wr), .offset(offset),
  .rdata(rdata), .shift_strobe(shift_strobe), .phase(phase),
  .motor_on(motor_on), .drive_sel(drive_sel), .write_mode(write_mode)
);

// File: tb/tb_disk_switch_ctrl.sv
module tb_disk_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, sel, wr;
  logic [3:0] offset;
  logic [7:0] wdata, shift_data, rdata;
  logic       shift_strobe, motor_on, drive_sel, write_mode;
  logic [3:0] phase;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  bit   m_ph[4];
  bit   m_mot, m_drv, m_wm;
  int   m_lat;

  disk_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .offset(offset),
    .wdata(wdata), .shift_data(shift_data), .rdata(rdata),
    .shift_strobe(shift_strobe), .phase(phase), .motor_on(motor_on),
    .drive_sel(drive_sel), .write_mode(write_mode)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic check_regs(string req);
    int ph_exp = 0;
    for (int i = 0; i < 4; i++) ph_exp |= int'(m_ph[i]) << i;
    chk({req, " phase"}, int'(phase), ph_exp);
    chk({req, " motor"}, int'(motor_on), int'(m_mot));
    chk({req, " drive"}, int'(drive_sel), int'(m_drv));
    chk({req, " mode"}, int'(write_mode), int'(m_wm));
  endtask

  // one access cycle: inputs at negedge, comb checks before edge, reg checks at next negedge
  task automatic step(bit s, bit w, int ofs, int wd, int sd);
    int exp_rd;
    string tag;
    sel = s; wr = w; offset = 4'(ofs); wdata = 8'(wd); shift_data = 8'(sd);
    #1;
    exp_rd = 0;
    if (s && !w && ofs == 12) exp_rd = sd;
    if (s && !w && ofs == 13) exp_rd = m_lat;
    if (s && !w && ofs == 12)      tag = "R6";
    else if (s && !w && ofs == 13) tag = "R7";
    else                           tag = "R9";
    chk({tag, " rdata"}, int'(rdata), exp_rd);
    chk("R5 strobe", int'(shift_strobe), int'(s && ofs == 12));
    @(posedge clk);
    if (s) begin
      if (ofs < 8)                 m_ph[ofs/2] = ofs[0];
      else if (ofs == 8 || ofs == 9)   m_mot = ofs[0];
      else if (ofs == 10 || ofs == 11) m_drv = ofs[0];
      else if (ofs == 13 && w)         m_lat = wd & 8'hFF;
      else if (ofs >= 14)              m_wm  = ofs[0];
    end
    @(negedge clk);
    if (!s)            tag = "R10";
    else if (ofs < 8)  tag = "R2";
    else if (ofs < 10) tag = "R3";
    else if (ofs < 12) tag = "R4";
    else if (ofs >= 14) tag = "R8";
    else               tag = "R7";
    check_regs(tag);
  endtask

  initial begin
    int lfsr = 16'hACE1;
    sel = 0; wr = 0; offset = 0; wdata = 0; shift_data = 0;
    rst_n = 0;
    for (int i = 0; i < 4; i++) m_ph[i] = 0;
    m_mot = 0; m_drv = 0; m_wm = 0; m_lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state, latch read back through offset D
    check_regs("R1");
    step(1, 0, 13, 0, 8'h5A);
    // every offset, both directions
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 16; o++)
        step(1, bit'(d), o, 8'h30 + o, 8'hC0 + o);
    // stepper walk: phases on in sequence then off
    for (int o = 1; o < 8; o += 2) step(1, 0, o, 0, 0);
    for (int o = 0; o < 8; o += 2) step(1, 1, o, 0, 0);
    // R7 latch write then reads; read of D does not load
    step(1, 1, 13, 8'hA5, 0);
    step(1, 0, 13, 8'h11, 0);
    step(1, 1, 12, 8'h22, 8'h3C);
    step(1, 0, 13, 0, 0);
    // R10 idle cycles with busy buses, then latch read back
    for (int i = 0; i < 8; i++) step(0, 1, 13 - i, 8'hFF, 8'hEE);
    step(1, 0, 13, 0, 0);
    // pseudo-random accesses
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      step(bit'((lfsr >> 5) & 1 | (lfsr >> 9) & 1), bit'((lfsr >> 4) & 1),
           lfsr & 15, (lfsr >> 6) & 255, (lfsr >> 8) & 255);
    end
    finish_run();
  end
endmodule